// File: doc/BRIEF.md
# GF(3) Bit-Sliced Polynomial Add/Negate Unit

This unit performs coefficient-wise arithmetic on polynomials over GF(3) with up to `N` coefficients (97 by default). Each operand is carried as a pair of `N`-bit words, a low word and a high word, which together encode every coefficient in two bits. All coefficient positions are combined in parallel with plain bitwise logic. No per-coefficient two-bit adder is used.

A caller presents two operands and a two-bit operation code together with a valid strobe. In the next cycle the unit returns the result in the same two-word form, along with a one-cycle valid pulse. In that same cycle it flags any input position that carries the illegal code. No reduction stage is needed, because adding or negating never raises the degree.

Top module: `gf3_slice_alu`

## Requirements
- R1: Coefficient i of an operand or result is encoded by bit i of the low word and bit i of the high word. Low set alone means 1, high set alone means 2, both clear means 0, and both set is illegal.
- R2: With op code 2'b00 the result holds A+B mod 3 in every coefficient position.
- R3: With op code 2'b01 the result holds A−B mod 3 in every coefficient position.
- R4: With op code 2'b10 the result holds −A mod 3, which is A with its low and high words exchanged.
- R5: With op code 2'b11 the result holds 2·A mod 3, which equals −A.
- R6: When valid_i is sampled high on a clock edge, valid_o is high for exactly the following cycle and the result words change at that same edge.
- R7: bad_code_o is high together with valid_o when any position of A or of B has both bits set, for every op code. When it is high, the content of the result words is unspecified.
- R8: When both inputs are legal, no position of the result has both bits set.
- R9: In a cycle that follows a clock edge where valid_i was low, valid_o and bad_code_o are low and the result words keep their previous values.
- R10: After reset, valid_o and bad_code_o are low and both result words are zero.
- R11: With op codes 2'b10 and 2'b11 the B operand does not affect the result words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 negate A, 11 double A |
| a_lo_i | input | N | Operand A, low word |
| a_hi_i | input | N | Operand A, high word |
| b_lo_i | input | N | Operand B, low word |
| b_hi_i | input | N | Operand B, high word |
| valid_o | output | 1 | Result valid pulse |
| res_lo_o | output | N | Result, low word |
| res_hi_o | output | N | Result, high word |
| bad_code_o | output | 1 | An input position held the illegal code |

## Verification
The assertion that forbids the illegal code in the output assumes that inputs marked legal really are legal. It is therefore guarded by bad_code_o. The negate check takes the unit's own A word swap as the meaning of both negate and double.

The stimulus draws every coefficient uniformly from {0,1,2}, so inputs are legal unless a test deliberately plants a both-set position. Planted positions are only used in the cases that exercise the error flag, and in those cycles the result words are not compared.

// File: rtl/gf3_pkg.sv
package gf3_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_DBL = 2'b11
  } gf3_op_e;
endpackage

// File: rtl/gf3_lane_add.sv
// Per-position GF(3) sum on split words: seven two-input gates per lane.
module gf3_lane_add #(
  parameter int unsigned W = 97
) (
  input  logic [W-1:0] x_lo_i,
  input  logic [W-1:0] x_hi_i,
  input  logic [W-1:0] y_lo_i,
  input  logic [W-1:0] y_hi_i,
  output logic [W-1:0] s_lo_o,
  output logic [W-1:0] s_hi_o
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    logic cross_a, cross_b, mix, hi_or, lo_or;
    assign cross_a   = x_lo_i[i] | y_hi_i[i];
    assign cross_b   = x_hi_i[i] | y_lo_i[i];
    assign mix       = cross_a ^ cross_b;
    assign hi_or     = x_hi_i[i] | y_hi_i[i];
    assign lo_or     = x_lo_i[i] | y_lo_i[i];
    assign s_lo_o[i] = hi_or ^ mix;
    assign s_hi_o[i] = lo_or ^ mix;
  end
endmodule

// File: rtl/gf3_operand_mux.sv
// Steers operands into the lane adder; negation is a word swap.
module gf3_operand_mux #(
  parameter int unsigned W = 97
) (
  input  gf3_pkg::gf3_op_e op_i,
  input  logic [W-1:0]     a_lo_i,
  input  logic [W-1:0]     a_hi_i,
  input  logic [W-1:0]     b_lo_i,
  input  logic [W-1:0]     b_hi_i,
  output logic [W-1:0]     x_lo_o,
  output logic [W-1:0]     x_hi_o,
  output logic [W-1:0]     y_lo_o,
  output logic [W-1:0]     y_hi_o
);
  import gf3_pkg::*;

  always_comb begin
    x_lo_o = a_lo_i;
    x_hi_o = a_hi_i;
    y_lo_o = b_lo_i;
    y_hi_o = b_hi_i;
    unique case (op_i)
      OP_ADD: ;
      OP_SUB: begin
        y_lo_o = b_hi_i;
        y_hi_o = b_lo_i;
      end
      OP_NEG, OP_DBL: begin
        // zero plus swapped A
        x_lo_o = '0;
        x_hi_o = '0;
        y_lo_o = a_hi_i;
        y_hi_o = a_lo_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gf3_code_scan.sv
module gf3_code_scan #(
  parameter int unsigned W = 97
) (
  input  logic [W-1:0] a_lo_i,
  input  logic [W-1:0] a_hi_i,
  input  logic [W-1:0] b_lo_i,
  input  logic [W-1:0] b_hi_i,
  output logic         bad_o
);
  logic [W-1:0] both_set;
  assign both_set = (a_lo_i & a_hi_i) | (b_lo_i & b_hi_i);
  assign bad_o    = |both_set;
endmodule

// File: rtl/gf3_slice_alu.sv
module gf3_slice_alu #(
  parameter int unsigned N = 97
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [1:0]   op_i,
  input  logic [N-1:0] a_lo_i,
  input  logic [N-1:0] a_hi_i,
  input  logic [N-1:0] b_lo_i,
  input  logic [N-1:0] b_hi_i,
  output logic         valid_o,
  output logic [N-1:0] res_lo_o,
  output logic [N-1:0] res_hi_o,
  output logic         bad_code_o
);
  import gf3_pkg::*;

  gf3_op_e      op;
  logic [N-1:0] x_lo, x_hi, y_lo, y_hi, s_lo, s_hi;
  logic         bad;

  assign op = gf3_op_e'(op_i);

  gf3_operand_mux #(.W(N)) u_mux (
    .op_i   (op),
    .a_lo_i (a_lo_i),
    .a_hi_i (a_hi_i),
    .b_lo_i (b_lo_i),
    .b_hi_i (b_hi_i),
    .x_lo_o (x_lo),
    .x_hi_o (x_hi),
    .y_lo_o (y_lo),
    .y_hi_o (y_hi)
  );

  gf3_lane_add #(.W(N)) u_add (
    .x_lo_i (x_lo),
    .x_hi_i (x_hi),
    .y_lo_i (y_lo),
    .y_hi_i (y_hi),
    .s_lo_o (s_lo),
    .s_hi_o (s_hi)
  );

  gf3_code_scan #(.W(N)) u_scan (
    .a_lo_i (a_lo_i),
    .a_hi_i (a_hi_i),
    .b_lo_i (b_lo_i),
    .b_hi_i (b_hi_i),
    .bad_o  (bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      bad_code_o <= 1'b0;
      res_lo_o   <= '0;
      res_hi_o   <= '0;
    end else begin
      valid_o    <= valid_i;
      bad_code_o <= valid_i & bad;
      if (valid_i) begin
        res_lo_o <= s_lo;
        res_hi_o <= s_hi;
      end
    end
  end

  // R6: one-cycle pulse after the strobe
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R9: idle cycle holds results and drops flags
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !bad_code_o && $stable(res_lo_o) && $stable(res_hi_o));

  // R8: legal in, legal out
  p_legal_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !bad_code_o) |-> ((res_lo_o & res_hi_o) == '0));

  // R7: flag only alongside a valid result
  p_flag_with_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_code_o |-> valid_o);

  // R4: negate swaps the A words
  p_neg_swap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10) |=> (res_lo_o == $past(a_hi_i)) && (res_hi_o == $past(a_lo_i)));
endmodule

// File: tb/sim_gf3_slice_alu.sv
`timescale 1ns/1ps
module sim_gf3_slice_alu;
  localparam int N = 97;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [N-1:0] a_lo_i = '0, a_hi_i = '0, b_lo_i = '0, b_hi_i = '0;
  logic         valid_o, bad_code_o;
  logic [N-1:0] res_lo_o, res_hi_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  gf3_slice_alu #(.N(N)) u0 (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_lo_i, .a_hi_i, .b_lo_i, .b_hi_i,
    .valid_o, .res_lo_o, .res_hi_o, .bad_code_o
  );

  always #2.5 clk_i = ~clk_i;

  // reference model state
  bit           m_valid = 0, m_bad = 0, m_known = 1;
  logic [N-1:0] m_lo = '0, m_hi = '0;

  function automatic int dec(logic l, logic h);
    return h ? 2 : (l ? 1 : 0);
  endfunction

  function automatic string tag(logic [1:0] op);
    case (op)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  logic [1:0] m_op = 2'b00;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      m_valid = valid_i;
      m_bad   = 1'b0;
      if (valid_i) begin
        m_op = op_i;
        for (int i = 0; i < N; i++) begin
          int a, b, r;
          if (a_lo_i[i] && a_hi_i[i]) m_bad = 1'b1;
          if (b_lo_i[i] && b_hi_i[i]) m_bad = 1'b1;
          a = dec(a_lo_i[i], a_hi_i[i]);
          b = dec(b_lo_i[i], b_hi_i[i]);
          case (op_i)
            2'b00:   r = (a + b) % 3;
            2'b01:   r = (a + 3 - b) % 3;
            2'b10:   r = (3 - a) % 3;
            default: r = (2 * a) % 3;
          endcase
          m_lo[i] = (r == 1);
          m_hi[i] = (r == 2);
        end
        m_known = !m_bad;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (valid_o !== m_valid) begin
        fails++;
        $display("FAIL R6/R9 valid_o got %0b exp %0b", valid_o, m_valid);
      end
      checks++;
      if (bad_code_o !== (m_valid && m_bad)) begin
        fails++;
        $display("FAIL R7 bad_code_o got %0b exp %0b", bad_code_o, m_valid && m_bad);
      end
      if (m_known) begin
        checks++;
        if (res_lo_o !== m_lo || res_hi_o !== m_hi) begin
          fails++;
          $display("FAIL %s result got %h/%h exp %h/%h",
                   m_valid ? tag(m_op) : "R9", res_lo_o, res_hi_o, m_lo, m_hi);
        end
        if (m_valid) begin
          checks++;
          if ((res_lo_o & res_hi_o) != '0) begin
            fails++;
            $display("FAIL R8 both-set in result got %h exp 0", res_lo_o & res_hi_o);
          end
        end
      end
    end
  end

  task automatic rand_poly(output logic [N-1:0] lo, output logic [N-1:0] hi);
    for (int i = 0; i < N; i++) begin
      int c = $urandom_range(2);
      lo[i] = (c == 1);
      hi[i] = (c == 2);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [N-1:0] al, ah, bl, bh);
    @(negedge clk_i);
    valid_i = 1'b1;
    op_i    = op;
    a_lo_i  = al; a_hi_i = ah; b_lo_i = bl; b_hi_i = bh;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      a_lo_i = $urandom; b_hi_i = $urandom;  // R9: ignored while idle
    end
  endtask

  logic [N-1:0] al, ah, bl, bh, neg_lo, neg_hi;

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10: reset state
    checks++;
    if (valid_o !== 1'b0 || bad_code_o !== 1'b0 || res_lo_o !== '0 || res_hi_o !== '0) begin
      fails++;
      $display("FAIL R10 reset outputs got %0b %0b %h %h exp 0 0 0 0",
               valid_o, bad_code_o, res_lo_o, res_hi_o);
    end
    rst_ni = 1'b1;
    idle(2);

    // R1/R2: x^6 + x + 2 plus itself -> 2x^6 + 2x + 1
    issue(2'b00, N'('b1000010), N'('b0000001), N'('b1000010), N'('b0000001));
    idle(1);
    checks++;
    if (res_lo_o !== N'('b0000001) || res_hi_o !== N'('b1000010)) begin
      fails++;
      $display("FAIL R1 encoded sum got %h/%h exp 1/42", res_lo_o, res_hi_o);
    end

    // R3: A - A = 0
    rand_poly(al, ah);
    issue(2'b01, al, ah, al, ah);
    idle(1);
    checks++;
    if (res_lo_o !== '0 || res_hi_o !== '0) begin
      fails++;
      $display("FAIL R3 self-subtract got %h/%h exp 0/0", res_lo_o, res_hi_o);
    end

    // R4/R5/R11: negate and double agree, B ignored
    rand_poly(al, ah);
    rand_poly(bl, bh);
    issue(2'b10, al, ah, bl, bh);
    idle(1);
    neg_lo = res_lo_o; neg_hi = res_hi_o;
    rand_poly(bl, bh);
    issue(2'b11, al, ah, bl, bh);
    idle(1);
    checks++;
    if (res_lo_o !== neg_lo || res_hi_o !== neg_hi) begin
      fails++;
      $display("FAIL R11 double vs negate got %h/%h exp %h/%h", res_lo_o, res_hi_o, neg_lo, neg_hi);
    end

    // all-twos + all-twos, all-ones - all-twos
    issue(2'b00, '0, '1, '0, '1);
    issue(2'b01, '1, '0, '0, '1);
    idle(1);

    // random, back-to-back, every op
    for (int n = 0; n < 400; n++) begin
      rand_poly(al, ah);
      rand_poly(bl, bh);
      issue(2'($urandom_range(3)), al, ah, bl, bh);
      if (n % 7 == 0) idle(1 + n % 3);
    end
    idle(2);

    // R7: plant illegal code in A, then in B, each op
    for (int op = 0; op < 4; op++) begin
      rand_poly(al, ah);
      rand_poly(bl, bh);
      al[op * 20] = 1'b1; ah[op * 20] = 1'b1;
      issue(2'(op), al, ah, bl, bh);
      rand_poly(al, ah);
      bl[N-1] = 1'b1; bh[N-1] = 1'b1;
      issue(2'(op), al, ah, bl, bh);
    end
    rand_poly(al, ah);
    rand_poly(bl, bh);
    issue(2'b00, al, ah, bl, bh);
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got hung exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule